// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Translator

This block turns the addresses that a console's CPU and picture processor put on the cartridge edge into physical addresses for the program ROM and the pattern memory. It also produces the nametable mirroring select. It is purely combinational. The caller supplies four already committed bank registers: a 5-bit control word, two pattern bank registers and a program bank register. The block does not load registers and does not handle board-specific bank extensions.

The CPU side covers the 32 KiB window from $8000 to $FFFF. The caller passes only address bits 14:0. The program address leaves the block as a bank number joined above a 14-bit offset. The pattern side covers the 8 KiB space from $0000 to $1FFF and leaves as a bank number joined above a 12-bit offset. The mirroring select comes out as a single bit that drives A10 of the console's nametable RAM.

Top module: `cart_bank_xlate`

## Requirements
- R1: When control bit 3 is 0 (32 KiB program mode), the program bank equals the program register with its bit 0 replaced by CPU A14. Control bit 2 has no effect in this mode.
- R2: When control bit 3 is 1 and bit 2 is 0, CPU addresses with A14=0 map to bank 0. Addresses with A14=1 map to the program register value.
- R3: When control bit 3 is 1 and bit 2 is 1, CPU addresses with A14=0 map to the program register value. Addresses with A14=1 map to the last bank, which is all ones (4'hF by default).
- R4: The program address output is {bank, CPU A13:0}, with the bank in the upper bits.
- R5: When control bit 4 is 0 (8 KiB pattern mode), the pattern bank equals pattern register 0 with its bit 0 replaced by PPU A12. Pattern register 1 has no effect in this mode.
- R6: When control bit 4 is 1 (4 KiB pattern mode), PPU A12=0 selects pattern register 0 and PPU A12=1 selects pattern register 1.
- R7: The pattern address output is {bank, PPU A11:0}, with the bank in the upper bits.
- R8: Control bits 1:0 select the nametable A10 output as follows: 00 gives constant 0, 01 gives constant 1, 10 gives PPU A10 (vertical), 11 gives PPU A11 (horizontal).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctrl_i | input | 5 | Control word: bit 4 pattern mode, bit 3 program size, bit 2 slot select, bits 1:0 mirroring |
| chr_lo_i | input | 5 | Pattern bank register 0 |
| chr_hi_i | input | 5 | Pattern bank register 1 |
| prg_bank_i | input | 4 | Program bank register |
| cpu_addr_i | input | 15 | CPU address bits 14:0 |
| ppu_addr_i | input | 13 | PPU address bits 12:0 |
| prg_addr_o | output | 18 | Program ROM address {bank, offset} |
| chr_addr_o | output | 17 | Pattern memory address {bank, offset} |
| ciram_a10_o | output | 1 | Nametable RAM A10 |

## Verification
The hardest cases to reach are the ones where one input must have no effect. Examples are the slot bit in 32 KiB mode and pattern register 1 in 8 KiB mode. A fixed pattern can hide such a leak, so the directed tasks hold every other input steady and toggle only the input that should be ignored. They then compare the outputs across the toggle. A final sweep walks all 32 control words, against every program bank value and a spread of addresses, and compares the outputs with an address function written separately in the bench.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

   localparam int CTRL_W = 5;

   typedef enum logic [1:0] {
      MIR_ONE_LO = 2'b00,
      MIR_ONE_HI = 2'b01,
      MIR_VERT   = 2'b10,
      MIR_HORZ   = 2'b11
   } mirror_e;

   // Field order follows the control word, bit 4 down to bit 0.
   typedef struct packed {
      logic    chr_split;
      logic    prg_half;
      logic    slot_lo_swap;
      mirror_e mir;
   } ctrl_t;

endpackage

// File: rtl/prg_xlate.sv
module prg_xlate #(
   parameter int BANK_W = 4,
   parameter int OFS_W  = 14
) (
   input  logic              prg_half_i,
   input  logic              slot_lo_swap_i,
   input  logic [BANK_W-1:0] bank_reg_i,
   input  logic [OFS_W:0]    cpu_addr_i,
   output logic [BANK_W+OFS_W-1:0] addr_o
);
   localparam logic [BANK_W-1:0] LAST_BANK = {BANK_W{1'b1}};
   localparam logic [BANK_W-1:0] FIRST_BANK = '0;

   logic              upper_half;
   logic [BANK_W-1:0] bank_pair;
   logic [BANK_W-1:0] bank_sel;

   assign upper_half = cpu_addr_i[OFS_W];
   assign bank_pair  = {bank_reg_i[BANK_W-1:1], upper_half};

   always_comb begin
      if (!prg_half_i)
         bank_sel = bank_pair;
      else if (slot_lo_swap_i)
         bank_sel = upper_half ? LAST_BANK : bank_reg_i;
      else
         bank_sel = upper_half ? bank_reg_i : FIRST_BANK;
   end

   assign addr_o = {bank_sel, cpu_addr_i[OFS_W-1:0]};
endmodule

// File: rtl/chr_xlate.sv
module chr_xlate #(
   parameter int BANK_W = 5,
   parameter int OFS_W  = 12
) (
   input  logic              split_i,
   input  logic [BANK_W-1:0] reg_lo_i,
   input  logic [BANK_W-1:0] reg_hi_i,
   input  logic [OFS_W:0]    ppu_addr_i,
   output logic [BANK_W+OFS_W-1:0] addr_o
);
   localparam int WINDOWS = 2;

   logic [BANK_W-1:0] win_bank [WINDOWS];
   logic              hi_window;

   assign hi_window = ppu_addr_i[OFS_W];

   // One candidate bank per 4 KiB window.
   for (genvar w = 0; w < WINDOWS; w++) begin : g_win
      logic [BANK_W-1:0] split_bank;
      logic [BANK_W-1:0] whole_bank;
      assign split_bank  = (w == 0) ? reg_lo_i : reg_hi_i;
      assign whole_bank  = {reg_lo_i[BANK_W-1:1], 1'(w)};
      assign win_bank[w] = split_i ? split_bank : whole_bank;
   end

   assign addr_o = {win_bank[hi_window], ppu_addr_i[OFS_W-1:0]};
endmodule

// File: rtl/mirror_sel.sv
module mirror_sel
   import cart_map_pkg::*;
(
   input  mirror_e mode_i,
   input  logic    ppu_a10_i,
   input  logic    ppu_a11_i,
   output logic    a10_o
);
   always_comb begin
      unique case (mode_i)
         MIR_ONE_LO: a10_o = 1'b0;
         MIR_ONE_HI: a10_o = 1'b1;
         MIR_VERT:   a10_o = ppu_a10_i;
         MIR_HORZ:   a10_o = ppu_a11_i;
         default:    a10_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate
   import cart_map_pkg::*;
#(
   parameter int PRG_BANK_W = 4,
   parameter int PRG_OFS_W  = 14,
   parameter int CHR_BANK_W = 5,
   parameter int CHR_OFS_W  = 12
) (
   input  logic [CTRL_W-1:0]               ctrl_i,
   input  logic [CHR_BANK_W-1:0]           chr_lo_i,
   input  logic [CHR_BANK_W-1:0]           chr_hi_i,
   input  logic [PRG_BANK_W-1:0]           prg_bank_i,
   input  logic [PRG_OFS_W:0]              cpu_addr_i,
   input  logic [CHR_OFS_W:0]              ppu_addr_i,
   output logic [PRG_BANK_W+PRG_OFS_W-1:0] prg_addr_o,
   output logic [CHR_BANK_W+CHR_OFS_W-1:0] chr_addr_o,
   output logic                            ciram_a10_o
);
   localparam int PRG_AW = PRG_BANK_W + PRG_OFS_W;
   localparam int CHR_AW = CHR_BANK_W + CHR_OFS_W;

   if (PRG_BANK_W < 2) begin : g_bad_prg
      $error("PRG_BANK_W must be at least 2");
   end
   if (CHR_BANK_W < 2) begin : g_bad_chr
      $error("CHR_BANK_W must be at least 2");
   end
   if (CHR_OFS_W < 11) begin : g_bad_chr_ofs
      $error("CHR_OFS_W must cover PPU A10 and A11");
   end

   ctrl_t ctrl;
   assign ctrl = ctrl_t'(ctrl_i);

   prg_xlate #(.BANK_W(PRG_BANK_W), .OFS_W(PRG_OFS_W)) u_prg (
      .prg_half_i     (ctrl.prg_half),
      .slot_lo_swap_i (ctrl.slot_lo_swap),
      .bank_reg_i     (prg_bank_i),
      .cpu_addr_i     (cpu_addr_i),
      .addr_o         (prg_addr_o)
   );

   chr_xlate #(.BANK_W(CHR_BANK_W), .OFS_W(CHR_OFS_W)) u_chr (
      .split_i    (ctrl.chr_split),
      .reg_lo_i   (chr_lo_i),
      .reg_hi_i   (chr_hi_i),
      .ppu_addr_i (ppu_addr_i),
      .addr_o     (chr_addr_o)
   );

   mirror_sel u_mir (
      .mode_i    (ctrl.mir),
      .ppu_a10_i (ppu_addr_i[10]),
      .ppu_a11_i (ppu_addr_i[11]),
      .a10_o     (ciram_a10_o)
   );

   // Checks relating the port values to the submodule results.
   always_comb begin
      if (ctrl_i[3] == 1'b0)
         p_prg32_pair_r1: assert (prg_addr_o[PRG_OFS_W] == cpu_addr_i[PRG_OFS_W]
                                  && prg_addr_o[PRG_AW-1:PRG_OFS_W+1] == prg_bank_i[PRG_BANK_W-1:1])
            else $error("32 KiB bank pairing broken");
      if (ctrl_i[3:2] == 2'b10 && cpu_addr_i[PRG_OFS_W] == 1'b0)
         p_prg_first_r2: assert (prg_addr_o[PRG_AW-1:PRG_OFS_W] == '0)
            else $error("lower slot not pinned to first bank");
      if (ctrl_i[3:2] == 2'b11 && cpu_addr_i[PRG_OFS_W] == 1'b1)
         p_prg_last_r3: assert (&prg_addr_o[PRG_AW-1:PRG_OFS_W])
            else $error("upper slot not pinned to last bank");
      if (cpu_addr_i[PRG_OFS_W-1:0] == cpu_addr_i[PRG_OFS_W-1:0])
         p_prg_offset_r4: assert (prg_addr_o[PRG_OFS_W-1:0] == cpu_addr_i[PRG_OFS_W-1:0])
            else $error("program offset altered");
      if (ctrl_i[4] == 1'b0)
         p_chr_whole_r5: assert (chr_addr_o[CHR_OFS_W] == ppu_addr_i[CHR_OFS_W])
            else $error("8 KiB pattern pairing broken");
      if (ctrl_i[4] == 1'b1 && ppu_addr_i[CHR_OFS_W] == 1'b1)
         p_chr_hi_r6: assert (chr_addr_o[CHR_AW-1:CHR_OFS_W] == chr_hi_i)
            else $error("upper 4 KiB window not from register 1");
      if (ctrl_i[1] == 1'b0)
         p_mirror_single_r8: assert (ciram_a10_o == ctrl_i[0])
            else $error("single-screen select wrong");
   end
endmodule

// File: tb/cart_bank_xlate_tb.sv
module cart_bank_xlate_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [4:0]  ctrl;
   logic [4:0]  chr_lo, chr_hi;
   logic [3:0]  prg_bank;
   logic [14:0] cpu_a;
   logic [12:0] ppu_a;
   logic [17:0] prg_addr;
   logic [16:0] chr_addr;
   logic        a10;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   cart_bank_xlate u_dut (
      .ctrl_i(ctrl), .chr_lo_i(chr_lo), .chr_hi_i(chr_hi), .prg_bank_i(prg_bank),
      .cpu_addr_i(cpu_a), .ppu_addr_i(ppu_a),
      .prg_addr_o(prg_addr), .chr_addr_o(chr_addr), .ciram_a10_o(a10)
   );

   function automatic int exp_prg(input logic [4:0] c, input logic [3:0] b, input logic [14:0] a);
      int bank;
      bit hi = a[14];
      if (!c[3])          bank = (int'(b) / 2) * 2 + (hi ? 1 : 0);
      else if (!c[2])     bank = hi ? int'(b) : 0;
      else                bank = hi ? 15 : int'(b);
      return bank * 16384 + int'(a[13:0]);
   endfunction

   function automatic int exp_chr(input logic [4:0] c, input logic [4:0] r0,
                                  input logic [4:0] r1, input logic [12:0] a);
      int bank;
      bit hi = a[12];
      if (!c[4]) bank = (int'(r0) / 2) * 2 + (hi ? 1 : 0);
      else       bank = hi ? int'(r1) : int'(r0);
      return bank * 4096 + int'(a[11:0]);
   endfunction

   function automatic bit exp_a10(input logic [4:0] c, input logic [12:0] a);
      case (c[1:0])
         2'd0: return 1'b0;
         2'd1: return 1'b1;
         2'd2: return a[10];
         default: return a[11];
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [4:0] c, input logic [4:0] r0, input logic [4:0] r1,
                        input logic [3:0] b, input logic [14:0] ca, input logic [12:0] pa);
      @(posedge clk);
      ctrl = c; chr_lo = r0; chr_hi = r1; prg_bank = b; cpu_a = ca; ppu_a = pa;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      drive(5'h00, 5'h00, 5'h00, 4'h0, 15'h0000, 13'h0000);
      check("R4 zero inputs prg", int'(prg_addr), 0);
      check("R7 zero inputs chr", int'(chr_addr), 0);
      check("R8 zero inputs a10", int'(a10), 0);
   endtask

   task automatic t_prg32();
      int ref_a;
      drive(5'b00000, 5'h00, 5'h00, 4'h7, 15'h4123, 13'h0);
      check("R1 32K upper half", int'(prg_addr), 7 * 16384 + 16'h0123);
      ref_a = int'(prg_addr);
      drive(5'b00100, 5'h00, 5'h00, 4'h7, 15'h4123, 13'h0);
      check("R1 slot bit ignored", int'(prg_addr), ref_a);
      drive(5'b00100, 5'h00, 5'h00, 4'h7, 15'h0123, 13'h0);
      check("R1 32K lower half", int'(prg_addr), 6 * 16384 + 16'h0123);
   endtask

   task automatic t_prg16_first();
      drive(5'b01000, 5'h00, 5'h00, 4'h9, 15'h0abc, 13'h0);
      check("R2 low slot fixed 0", int'(prg_addr), 16'h0abc);
      drive(5'b01000, 5'h00, 5'h00, 4'h9, 15'h7abc, 13'h0);
      check("R2 high slot from reg", int'(prg_addr), 9 * 16384 + 16'h3abc);
   endtask

   task automatic t_prg16_last();
      drive(5'b01100, 5'h00, 5'h00, 4'h3, 15'h1234, 13'h0);
      check("R3 low slot from reg", int'(prg_addr), 3 * 16384 + 16'h1234);
      drive(5'b01100, 5'h00, 5'h00, 4'h3, 15'h7fff, 13'h0);
      check("R3 high slot fixed F", int'(prg_addr), 15 * 16384 + 16'h3fff);
   endtask

   task automatic t_chr_whole();
      int ref_a;
      drive(5'b00000, 5'h0b, 5'h00, 4'h0, 15'h0, 13'h0456);
      check("R5 8K low window", int'(chr_addr), 10 * 4096 + 16'h0456);
      drive(5'b00000, 5'h0b, 5'h1f, 4'h0, 15'h0, 13'h1456);
      check("R5 8K high window", int'(chr_addr), 11 * 4096 + 16'h0456);
      ref_a = int'(chr_addr);
      drive(5'b00000, 5'h0b, 5'h04, 4'h0, 15'h0, 13'h1456);
      check("R5 reg1 ignored", int'(chr_addr), ref_a);
   endtask

   task automatic t_chr_split();
      drive(5'b10000, 5'h13, 5'h0c, 4'h0, 15'h0, 13'h0fff);
      check("R6 low window reg0", int'(chr_addr), 19 * 4096 + 16'h0fff);
      drive(5'b10000, 5'h13, 5'h0c, 4'h0, 15'h0, 13'h1001);
      check("R6 high window reg1", int'(chr_addr), 12 * 4096 + 16'h0001);
   endtask

   task automatic t_mirror();
      for (int m = 0; m < 4; m++) begin
         for (int q = 0; q < 4; q++) begin
            logic [12:0] pa;
            pa = 13'(q * 1024 + 5);
            drive(5'(m), 5'h0, 5'h0, 4'h0, 15'h0, pa);
            check("R8 mirroring", int'(a10), int'(exp_a10(5'(m), pa)));
         end
      end
   endtask

   task automatic t_sweep();
      for (int c = 0; c < 32; c++) begin
         for (int b = 0; b < 16; b++) begin
            for (int k = 0; k < 3; k++) begin
               logic [14:0] ca;
               logic [12:0] pa;
               ca = 15'(k * 16'h2a55 + b * 16'h0103);
               pa = 13'(k * 16'h0b37 + b * 16'h0211);
               drive(5'(c), 5'(b * 3 + 1), 5'(b * 5 + 2), 4'(b), ca, pa);
               check("R1 R2 R3 R4 sweep prg", int'(prg_addr), exp_prg(5'(c), 4'(b), ca));
               check("R5 R6 R7 sweep chr", int'(chr_addr),
                     exp_chr(5'(c), 5'(b * 3 + 1), 5'(b * 5 + 2), pa));
               check("R8 sweep a10", int'(a10), int'(exp_a10(5'(c), pa)));
            end
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_prg32();
      t_prg16_first();
      t_prg16_last();
      t_chr_whole();
      t_chr_split();
      t_mirror();
      t_sweep();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule